// File: doc/BRIEF.md
# Sub-Dword Operand Select and Merge Unit

This unit wraps a 32-bit integer ALU with lane-selection logic on both sides. Each of the two source operands passes through its own extractor, which picks the whole word, one of four bytes or one of two halfwords. A picked byte or halfword is zero-extended to 32 bits, or sign-extended when that operand's extension bit is set. The two extended operands feed a small ALU that adds, ANDs or ORs them.

On the output side, the low bits of the ALU result are placed into a chosen byte or halfword field of the destination word. The caller supplies the old destination word. The bits outside the field are filled by one of three policies: they keep their old value, they are cleared, or the bits above the field copy its sign while the bits below it are cleared.

Both the raw ALU result and the merged destination word are registered. They appear one clock after the operands are presented.

Top module: `subdword_alu_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and `alu_res` and `dst_new` are all zeros.
- R2: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1. The results for that operation are present in that same cycle. When `in_valid` is 0, `out_valid` is 0 one cycle later.
- R3: `op` selects the ALU function: 0 adds modulo 2^32, 1 is bitwise AND, 2 is bitwise OR, and 3 behaves as add.
- R4: `sel_a`/`sel_b` encodings are as follows. 0 is the full word (bits 31:0). 1, 2, 3 and 4 are byte 0 to byte 3 (bits 7:0, 15:8, 23:16, 31:24). 5 is the low halfword (bits 15:0) and 6 is the high halfword (bits 31:16). 7 acts as 0.
- R5: With the operand's extension bit at 0, a selected byte or halfword is zero-extended to 32 bits before the ALU.
- R6: With the extension bit at 1, a selected byte or halfword is sign-extended from its top bit. For a full-word select, the extension bit has no effect.
- R7: `dst_sel` uses the R4 encodings. A byte or halfword field receives the low 8 or 16 bits of the ALU result. With a full-word `dst_sel`, `dst_new` equals the ALU result whatever `fill` is.
- R8: `fill` = 1 (clear) makes every `dst_new` bit outside the field zero.
- R9: `fill` = 2 (sign) sets every bit above the field to the field's top bit and clears every bit below the field.
- R10: `fill` = 0 (keep, the default) takes every bit outside the field from `dst_old`. `fill` = 3 acts as 0.
- R11: `alu_res` carries the full 32-bit ALU result, unaffected by `dst_sel`, `fill` and `dst_old`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 2 | ALU function select |
| src_a | input | 32 | First source word |
| sel_a | input | 3 | Lane select for the first source |
| sext_a | input | 1 | Sign-extend the first source's selected lane |
| src_b | input | 32 | Second source word |
| sel_b | input | 3 | Lane select for the second source |
| sext_b | input | 1 | Sign-extend the second source's selected lane |
| dst_sel | input | 3 | Destination field select |
| fill | input | 2 | Policy for destination bits outside the field |
| dst_old | input | 32 | Prior destination word, used by the keep policy |
| out_valid | output | 1 | Results valid |
| alu_res | output | 32 | Registered ALU result |
| dst_new | output | 32 | Registered merged destination word |

## Verification
Extraction of a signed sub-dword lane and the sign policy on the destination both act on the same operation. Tests therefore pick lanes whose top bit is set, so that the two sign decisions interact in one cycle. For example, a sign-extended negative byte is added to a low halfword, and the result is merged into the high byte under the sign policy. The result is judged bit by bit against an independent per-bit model of extraction and merge. Operations are also issued back to back with differing `dst_sel` and `fill` on consecutive cycles, so that any stale policy or field state shows up as a mismatch in the scoreboard.

// File: rtl/subsel_pkg.sv
package subsel_pkg;

    typedef enum logic [2:0] {
        LANE_FULL = 3'd0,
        LANE_B0   = 3'd1,
        LANE_B1   = 3'd2,
        LANE_B2   = 3'd3,
        LANE_B3   = 3'd4,
        LANE_H0   = 3'd5,
        LANE_H1   = 3'd6,
        LANE_RSV  = 3'd7
    } lane_e;

    typedef enum logic [1:0] {
        FILL_KEEP = 2'd0,
        FILL_ZERO = 2'd1,
        FILL_SIGN = 2'd2,
        FILL_RSV  = 2'd3
    } fill_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_AND = 2'd1,
        ALU_OR  = 2'd2,
        ALU_ALT = 2'd3
    } alu_op_e;

endpackage

// File: rtl/operand_extract.sv
module operand_extract
    import subsel_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    input  lane_e             sel,
    input  logic              sext,
    output logic [DATA_W-1:0] ext
);
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = DATA_W / 2;
    localparam int N_BYTES = DATA_W / BYTE_W;

    logic [BYTE_W-1:0] byte_lane [N_BYTES];
    logic [HALF_W-1:0] half_lane [2];

    for (genvar g = 0; g < N_BYTES; g++) begin : g_bytes
        assign byte_lane[g] = src[g*BYTE_W +: BYTE_W];
    end
    for (genvar h = 0; h < 2; h++) begin : g_halves
        assign half_lane[h] = src[h*HALF_W +: HALF_W];
    end

    logic [1:0] byte_idx;

    always_comb begin
        byte_idx = 2'(sel - LANE_B0);
        unique case (sel)
            LANE_B0, LANE_B1, LANE_B2, LANE_B3:
                ext = {{(DATA_W-BYTE_W){sext & byte_lane[byte_idx][BYTE_W-1]}},
                       byte_lane[byte_idx]};
            LANE_H0:
                ext = {{(DATA_W-HALF_W){sext & half_lane[0][HALF_W-1]}}, half_lane[0]};
            LANE_H1:
                ext = {{(DATA_W-HALF_W){sext & half_lane[1][HALF_W-1]}}, half_lane[1]};
            default:
                ext = src;
        endcase
    end
endmodule

// File: rtl/simple_alu.sv
module simple_alu
    import subsel_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/field_merge.sv
module field_merge
    import subsel_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] old,
    input  lane_e             dsel,
    input  fill_e             fill,
    output logic [DATA_W-1:0] merged
);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int BYTE_W = 8;
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic              is_full;
    logic [IDX_W:0]    lsb;
    logic [IDX_W:0]    wid;
    logic [IDX_W-1:0]  top_idx;
    logic              field_msb;
    logic [DATA_W-1:0] field_mask;
    logic [DATA_W-1:0] below_mask;
    logic [DATA_W-1:0] above_mask;
    logic [DATA_W-1:0] placed;
    logic [DATA_W-1:0] outside;

    always_comb begin
        is_full = 1'b0;
        lsb     = '0;
        wid     = (IDX_W+1)'(BYTE_W);
        unique case (dsel)
            LANE_B0: lsb = (IDX_W+1)'(0);
            LANE_B1: lsb = (IDX_W+1)'(BYTE_W);
            LANE_B2: lsb = (IDX_W+1)'(2*BYTE_W);
            LANE_B3: lsb = (IDX_W+1)'(3*BYTE_W);
            LANE_H0: begin lsb = '0; wid = (IDX_W+1)'(HALF_W); end
            LANE_H1: begin lsb = (IDX_W+1)'(HALF_W); wid = (IDX_W+1)'(HALF_W); end
            default: is_full = 1'b1;
        endcase

        top_idx    = IDX_W'(wid - 1'b1);
        field_msb  = res[top_idx];
        field_mask = ((ONE << wid) - ONE) << lsb;
        below_mask = (ONE << lsb) - ONE;
        above_mask = ~(field_mask | below_mask);
        placed     = (res << lsb) & field_mask;

        unique case (fill)
            FILL_ZERO: outside = '0;
            FILL_SIGN: outside = {DATA_W{field_msb}} & above_mask;
            default:   outside = old & ~field_mask;
        endcase

        merged = is_full ? res : (placed | outside);
    end
endmodule

// File: rtl/subdword_alu_unit.sv
module subdword_alu_unit
    import subsel_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [2:0]        sel_a,
    input  logic              sext_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [2:0]        sel_b,
    input  logic              sext_b,
    input  logic [2:0]        dst_sel,
    input  logic [1:0]        fill,
    input  logic [DATA_W-1:0] dst_old,
    output logic              out_valid,
    output logic [DATA_W-1:0] alu_res,
    output logic [DATA_W-1:0] dst_new
);
    localparam int N_SRC = 2;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] dst;
    } stage_t;

    logic [DATA_W-1:0] src_arr [N_SRC];
    lane_e             sel_arr [N_SRC];
    logic              sx_arr  [N_SRC];
    logic [DATA_W-1:0] ext_arr [N_SRC];

    assign src_arr[0] = src_a;
    assign src_arr[1] = src_b;
    assign sel_arr[0] = lane_e'(sel_a);
    assign sel_arr[1] = lane_e'(sel_b);
    assign sx_arr[0]  = sext_a;
    assign sx_arr[1]  = sext_b;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        operand_extract #(.DATA_W(DATA_W)) u_ext (
            .src  (src_arr[s]),
            .sel  (sel_arr[s]),
            .sext (sx_arr[s]),
            .ext  (ext_arr[s])
        );
    end

    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] merge_y;

    simple_alu #(.DATA_W(DATA_W)) u_alu (
        .op (alu_op_e'(op)),
        .a  (ext_arr[0]),
        .b  (ext_arr[1]),
        .y  (alu_y)
    );

    field_merge #(.DATA_W(DATA_W)) u_merge (
        .res    (alu_y),
        .old    (dst_old),
        .dsel   (lane_e'(dst_sel)),
        .fill   (fill_e'(fill)),
        .merged (merge_y)
    );

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = alu_y;
            st_d.dst = merge_y;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign alu_res   = st_q.res;
    assign dst_new   = st_q.dst;

    // R2: one-cycle latency, no output without a request
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: full-word destination mirrors the ALU result
    a_r7_full_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_sel == LANE_FULL) |=> (dst_new == alu_res));

    // R8: clear policy around the low halfword
    a_r8_zero_above: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fill == FILL_ZERO && dst_sel == LANE_H0) |=> (dst_new[31:16] == 16'h0));

    // R9: sign policy clears everything below the top byte
    a_r9_sign_below: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fill == FILL_SIGN && dst_sel == LANE_B3) |=> (dst_new[23:0] == 24'h0));

    // R10: keep policy preserves the old bits around byte 1
    a_r10_keep_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fill == FILL_KEEP && dst_sel == LANE_B1) |=>
        (dst_new[7:0] == $past(dst_old[7:0]) && dst_new[31:16] == $past(dst_old[31:16])));

    // R5: AND with a zero-extended byte cannot set upper bits
    a_r5_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == ALU_AND && sel_a == LANE_B2 && !sext_a) |=> (alu_res[31:8] == 24'h0));
endmodule

// File: tb/subdword_alu_unit_test.sv
module subdword_alu_unit_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0;
    logic [31:0] src_a = '0, src_b = '0, dst_old = '0;
    logic [2:0]  sel_a = '0, sel_b = '0, dst_sel = '0;
    logic        sext_a = 1'b0, sext_b = 1'b0;
    logic [1:0]  fill = '0;
    logic        out_valid;
    logic [31:0] alu_res, dst_new;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        string       tag;
        logic [31:0] res;
        logic [31:0] dst;
    } exp_t;
    exp_t sbq[$];

    always #(PERIOD/2) clk = ~clk;

    subdword_alu_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .sel_a(sel_a), .sext_a(sext_a),
        .src_b(src_b), .sel_b(sel_b), .sext_b(sext_b),
        .dst_sel(dst_sel), .fill(fill), .dst_old(dst_old),
        .out_valid(out_valid), .alu_res(alu_res), .dst_new(dst_new)
    );

    function automatic void lane_geom(input int sel, output int lo, output int w);
        case (sel)
            1: begin lo = 0;  w = 8;  end
            2: begin lo = 8;  w = 8;  end
            3: begin lo = 16; w = 8;  end
            4: begin lo = 24; w = 8;  end
            5: begin lo = 0;  w = 16; end
            6: begin lo = 16; w = 16; end
            default: begin lo = 0; w = 32; end
        endcase
    endfunction

    function automatic logic [31:0] m_ext(logic [31:0] v, int sel, bit sx);
        int lo, w;
        logic [31:0] r;
        lane_geom(sel, lo, w);
        r = '0;
        for (int i = 0; i < w; i++) r[i] = v[lo+i];
        for (int i = w; i < 32; i++) r[i] = sx ? v[lo+w-1] : 1'b0;
        return r;
    endfunction

    function automatic logic [31:0] m_alu(int o, logic [31:0] a, logic [31:0] b);
        case (o)
            1: return a & b;
            2: return a | b;
            default: return a + b;
        endcase
    endfunction

    function automatic logic [31:0] m_merge(logic [31:0] r, logic [31:0] old, int sel, int fl);
        int lo, w;
        logic [31:0] d;
        lane_geom(sel, lo, w);
        if (w == 32) return r;
        for (int i = 0; i < 32; i++) begin
            if (i >= lo && i < lo + w) d[i] = r[i-lo];
            else if (fl == 1)          d[i] = 1'b0;
            else if (fl == 2)          d[i] = (i < lo) ? 1'b0 : r[w-1];
            else                       d[i] = old[i];
        end
        return d;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(string tag, int o, logic [31:0] a, int sa, bit xa,
                         logic [31:0] b, int sb, bit xb, int ds, int fl, logic [31:0] old);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; op = 2'(o);
        src_a = a; sel_a = 3'(sa); sext_a = xa;
        src_b = b; sel_b = 3'(sb); sext_b = xb;
        dst_sel = 3'(ds); fill = 2'(fl); dst_old = old;
        e.tag = tag;
        e.res = m_alu(o, m_ext(a, sa, xa), m_ext(b, sb, xb));
        e.dst = m_merge(e.res, old, ds, fl);
        sbq.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: a quarter period after each edge, R2 validity and scoreboard compare
    always @(posedge clk) begin
        #(PERIOD/4);
        if (rst_n) begin
            check("R2 out_valid", {31'b0, out_valid}, {31'b0, in_valid});
            if (out_valid) begin
                if (sbq.size() == 0) begin
                    check("R2 unexpected result", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check({e.tag, " R11 alu_res"}, alu_res, e.res);
                    check({e.tag, " dst_new"}, dst_new, e.dst);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {31'b0, out_valid}, 32'h0);
        check("R1 alu_res in reset", alu_res, 32'h0);
        check("R1 dst_new in reset", dst_new, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", {31'b0, out_valid}, 32'h0);
        check("R1 dst_new after reset", dst_new, 32'h0);

        // R3 ALU functions
        drive("R3 add wrap", 0, 32'hFFFF_FFFF, 0, 0, 32'h1, 0, 0, 0, 0, 32'h0);
        drive("R3 and",      1, 32'hF0F0_1234, 0, 0, 32'h0FF0_FF00, 0, 0, 0, 0, 32'h0);
        drive("R3 or",       2, 32'hA000_0005, 0, 0, 32'h0500_0050, 0, 0, 0, 0, 32'h0);
        drive("R3 op3 add",  3, 32'h1234_5678, 0, 0, 32'h1111_1111, 0, 0, 0, 0, 32'h0);
        idle(1);
        // R4 lanes
        for (int s = 0; s < 8; s++)
            drive("R4 lane sel", 2, 32'h8765_43A1, s, 0, 32'h0, 0, 0, 0, 0, 32'h0);
        drive("R4 sel_b byte3", 2, 32'h0, 0, 0, 32'hC4_000000, 4, 0, 0, 0, 32'h0);
        // R5 / R6 extension
        drive("R5 zero-ext byte2", 1, 32'h00F3_0000, 3, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 32'h0);
        drive("R6 sext byte1",     0, 32'h0000_8000, 2, 1, 32'h0, 0, 0, 0, 0, 32'h0);
        drive("R6 sext high half", 0, 32'h8001_0000, 6, 1, 32'h1, 5, 1, 0, 0, 32'h0);
        drive("R6 sext full none", 0, 32'h8000_0000, 0, 1, 32'h1, 0, 1, 0, 0, 32'h0);
        drive("R6 sext positive",  0, 32'h0000_007F, 1, 1, 32'h0, 0, 0, 0, 0, 32'h0);
        idle(2);
        // R7 destination field
        drive("R7 full dst ignores fill", 0, 32'h1234_5678, 0, 0, 32'h1, 0, 0, 0, 1, 32'hDEAD_BEEF);
        drive("R7 field byte2 keep",      0, 32'h0000_00AB, 0, 0, 32'h0, 0, 0, 3, 0, 32'h1122_3344);
        drive("R7 field high half",       0, 32'h0000_BEEF, 0, 0, 32'h0, 0, 0, 6, 1, 32'hFFFF_FFFF);
        // R8 clear
        drive("R8 clear byte1", 0, 32'h0000_00C3, 0, 0, 32'h0, 0, 0, 2, 1, 32'hFFFF_FFFF);
        drive("R8 clear half0", 0, 32'hFFFF_8001, 0, 0, 32'h0, 0, 0, 5, 1, 32'hFFFF_FFFF);
        // R9 sign policy
        drive("R9 sign byte1 neg", 0, 32'h0000_0080, 0, 0, 32'h0, 0, 0, 2, 2, 32'hFFFF_FFFF);
        drive("R9 sign byte1 pos", 0, 32'h0000_007F, 0, 0, 32'h0, 0, 0, 2, 2, 32'hFFFF_FFFF);
        drive("R9 sign byte3",     0, 32'h0000_0090, 0, 0, 32'h0, 0, 0, 4, 2, 32'hFFFF_FFFF);
        drive("R9 sign half0 neg", 0, 32'h0000_9000, 0, 0, 32'h0, 0, 0, 5, 2, 32'h0);
        // R10 keep
        drive("R10 keep byte1",     2, 32'h0000_005A, 0, 0, 32'h0, 0, 0, 2, 0, 32'hA1B2_C3D4);
        drive("R10 keep fill3",     2, 32'h0000_0066, 0, 0, 32'h0, 0, 0, 1, 3, 32'h9988_7766);
        drive("R10 keep half1",     2, 32'h0000_1357, 0, 0, 32'h0, 0, 0, 6, 0, 32'hCAFE_F00D);
        // Combined: signed byte plus signed half into byte3 with sign policy, back to back
        drive("R6 R9 combined", 0, 32'h00F0_0000, 3, 1, 32'h0000_8005, 5, 1, 4, 2, 32'h5555_5555);
        drive("R4 R8 combined", 2, 32'h7700_0000, 4, 0, 32'h00FF_0000, 3, 1, 1, 1, 32'h5555_5555);
        drive("R5 R10 combined", 0, 32'hFF00_0000, 4, 0, 32'h0001_0000, 6, 0, 5, 0, 32'h3333_3333);
        idle(4);
        check("R2 scoreboard drained", sbq.size(), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule